// File: doc/BRIEF.md
# Peripheral Bus Strobe and Interrupt Vector Decoder

This block sits between a CPU with a 20-bit address bus and a peripheral bus that works on a select-then-access scheme. In that scheme a card is chosen first and then accessed. When the CPU runs an I/O cycle, the block asserts one of eight active-low strobe lines. An I/O cycle is one where address bit 19 is high while the address strobe is low. Address bits 2..0 pick which strobe asserts. The block also passes CPU address bits 13..8 to the six register-address lines of the peripheral bus.

In an interrupt-acknowledge cycle the CPU places the level on the low address bits and sets every other bit high. At level 2 this gives bits 2..0 = 101, which selects the interrupt-read strobe at index 5. While that strobe is active, every card drives its assigned data line. A card drives 0 when it has an interrupt pending and 1 when it has none. Lines that no card drives are held at 1 by pull-ups. The block contains a model of this wired-AND data bus with its pull-ups. The vector the CPU reads is therefore 0xFF with the bit of each pending card cleared. Only lines 0 to 6 may be assigned to cards, so the vector always lies between 0x80 and 0xFF.

Strobes and forwarded address lines are registered, so they follow the sampled inputs one clock later. The vector is formed combinationally from the registered interrupt-read strobe and the cards' pending inputs.

Top module: `pbus_strobe_decode`

## Requirements
- R1: While reset is active and right after it, all eight strobes are high, the register-address lines are 0 and the vector bus reads 0xFF.
- R2: If, at a clock edge, address strobe is high or address bit 19 is low, then after that edge all eight strobes are high.
- R3: If, at a clock edge, address strobe is low and address bit 19 is high, then after that edge exactly one strobe is low. Its index is the value of address bits 2..0.
- R4: Indices 0 to 3 form the write group and indices 4 to 7 the read group, so address bit 2 = 1 selects a read strobe. The assignment is: 0 write-high latch, 1 write data, 2 card select, 3 write interrupt, 4 read serial-EEPROM bus, 5 read interrupt, 6 read-high latch, 7 read data.
- R5: A level-2 interrupt-acknowledge address has bit 19 set and low bits ...10101. Such an address asserts the read-interrupt strobe (index 5) and no other.
- R6: While the read-interrupt strobe is low, the vector is 0xFF with bit i cleared for each card line i (0..6) whose interrupt is pending. Bit 7 always reads 1.
- R7: While the read-interrupt strobe is high, the vector bus reads 0xFF, whatever interrupts are pending.
- R8: After each clock edge the register-address lines 5..0 equal CPU address bits 13..8 sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| as_n | input | 1 | CPU address strobe, active low |
| cpu_a19 | input | 1 | CPU address bit 19 (I/O space when high) |
| cpu_alo | input | 3 | CPU address bits 2..0, strobe index |
| cpu_amid | input | 6 | CPU address bits 13..8 |
| irq_pend | input | 7 | Pending interrupt of the card on each data line 0..6 |
| strb_n | output | 8 | Active-low peripheral strobes |
| per_addr | output | 6 | Peripheral register-address lines |
| irq_vec | output | 8 | Data-bus value seen by the CPU (wired-AND with pull-ups) |

## Verification
Some properties are checked by assertions on every cycle. These are: strobes stay high when there is no I/O cycle, at most one strobe is low, a decoded I/O cycle drives the strobe whose index was on the sampled address bits, and bit 7 of the vector always reads 1. The vector reads 0xFF whenever the interrupt-read strobe is idle, and the register-address lines follow the sampled address. Only the bench's scenarios can show the rest. These cover the fixed name of each strobe index and the acknowledge cycle reaching index 5. They also cover the vector values produced by single pending cards, several pending cards and all seven pending cards, which the bench compares against a separate model of the wired-AND bus.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
    parameter int SELW  = 3;
    parameter int NSTB  = 1 << SELW;
    parameter int PAW   = 6;
    parameter int DW    = 8;
    parameter int NCARD = 7;

    localparam int STB_WR_HI  = 0;
    localparam int STB_WR_DAT = 1;
    localparam int STB_SELECT = 2;
    localparam int STB_WR_IRQ = 3;
    localparam int STB_RD_I2C = 4;
    localparam int STB_RD_IRQ = 5;
    localparam int STB_RD_HI  = 6;
    localparam int STB_RD_DAT = 7;

    typedef struct packed {
        logic [NSTB-1:0] strb_n;
        logic [PAW-1:0]  paddr;
    } dec_regs_t;
endpackage

// File: rtl/pbus_strobe_sel.sv
module pbus_strobe_sel #(
    parameter int SELW = 3,
    localparam int NSTB = 1 << SELW
) (
    input  logic            en,
    input  logic [SELW-1:0] sel,
    output logic [NSTB-1:0] strb_n
);
    for (genvar i = 0; i < NSTB; i++) begin : g_stb
        assign strb_n[i] = !(en && (sel == SELW'(i)));
    end
endmodule

// File: rtl/pbus_vec_bus.sv
module pbus_vec_bus #(
    parameter int DW    = 8,
    parameter int NCARD = 7
) (
    input  logic             rd_irq_n,
    input  logic [NCARD-1:0] pend,
    output logic [DW-1:0]    bus
);
    for (genvar i = 0; i < DW; i++) begin : g_line
        if (i < NCARD) begin : g_card
            // card drives 0 only when strobed and pending; else pull-up wins
            assign bus[i] = rd_irq_n | ~pend[i];
        end else begin : g_pullup
            assign bus[i] = 1'b1;
        end
    end

    always_comb begin
        assert_top_bit_R6: assert (bus[DW-1] == 1'b1);
    end
endmodule

// File: rtl/pbus_strobe_decode.sv
module pbus_strobe_decode
    import pbus_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             as_n,
    input  logic             cpu_a19,
    input  logic [SELW-1:0]  cpu_alo,
    input  logic [PAW-1:0]   cpu_amid,
    input  logic [NCARD-1:0] irq_pend,
    output logic [NSTB-1:0]  strb_n,
    output logic [PAW-1:0]   per_addr,
    output logic [DW-1:0]    irq_vec
);
    dec_regs_t       regs_d, regs_q;
    logic            io_cycle;
    logic [NSTB-1:0] strb_dec;

    assign io_cycle = !as_n && cpu_a19;

    pbus_strobe_sel #(.SELW(SELW)) i_sel (
        .en     (io_cycle),
        .sel    (cpu_alo),
        .strb_n (strb_dec)
    );

    always_comb begin
        regs_d        = regs_q;
        regs_d.strb_n = strb_dec;
        regs_d.paddr  = cpu_amid;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q.strb_n <= '1;
            regs_q.paddr  <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign strb_n   = regs_q.strb_n;
    assign per_addr = regs_q.paddr;

    pbus_vec_bus #(.DW(DW), .NCARD(NCARD)) i_vec (
        .rd_irq_n (regs_q.strb_n[STB_RD_IRQ]),
        .pend     (irq_pend),
        .bus      (irq_vec)
    );

    assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (as_n || !cpu_a19) |=> (strb_n == '1));

    assert_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~strb_n));

    assert_index_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!as_n && cpu_a19) |=> (strb_n[$past(cpu_alo)] == 1'b0));

    assert_vec_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        strb_n[STB_RD_IRQ] |-> (irq_vec == '1));

    assert_fwd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (per_addr == $past(cpu_amid)));
endmodule

// File: tb/test_pbus_strobe_decode.sv
module test_pbus_strobe_decode;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       as_n = 1'b1;
    logic       cpu_a19 = 1'b0;
    logic [2:0] cpu_alo = '0;
    logic [5:0] cpu_amid = '0;
    logic [6:0] irq_pend = '0;
    logic [7:0] strb_n;
    logic [5:0] per_addr;
    logic [7:0] irq_vec;

    int n_run = 0;
    int n_fail = 0;

    typedef struct {
        logic [7:0] strb;
        logic [5:0] addr;
        logic [7:0] vec;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    bit   drv_done = 0;

    always #4 clk = ~clk;

    pbus_strobe_decode i_pbus_strobe_decode (
        .clk(clk), .rst_n(rst_n), .as_n(as_n), .cpu_a19(cpu_a19),
        .cpu_alo(cpu_alo), .cpu_amid(cpu_amid), .irq_pend(irq_pend),
        .strb_n(strb_n), .per_addr(per_addr), .irq_vec(irq_vec)
    );

    task automatic check(input string tag, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic drive(input logic a_n, input logic a19, input logic [2:0] lo,
                         input logic [5:0] mid, input logic [6:0] pend,
                         input string tag);
        exp_t e;
        bit   io;
        @(negedge clk);
        as_n = a_n; cpu_a19 = a19; cpu_alo = lo; cpu_amid = mid; irq_pend = pend;
        io     = !a_n && a19;
        e.strb = io ? ~(8'b1 << lo) : 8'hFF;
        e.addr = mid;
        e.vec  = (io && lo == 3'd5) ? {1'b1, ~pend} : 8'hFF;
        e.tag  = tag;
        exp_q.push_back(e);
    endtask

    initial begin : monitor
        exp_t e;
        @(posedge rst_n);
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                check(e.tag, "strobes", strb_n, e.strb);
                check(e.tag, "reg-address", {2'b00, per_addr}, {2'b00, e.addr});
                check(e.tag, "vector", irq_vec, e.vec);
            end
        end
    end

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : driver
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check("R1", "strobes", strb_n, 8'hFF);
        check("R1", "reg-address", {2'b00, per_addr}, 8'h00);
        check("R1", "vector", irq_vec, 8'hFF);
        @(negedge clk);
        rst_n = 1'b1;
        // R2: no I/O cycle -> strobes idle
        drive(1'b1, 1'b1, 3'd5, 6'h15, 7'h7F, "R2");
        drive(1'b0, 1'b0, 3'd5, 6'h2A, 7'h7F, "R2");
        // R3/R4: every index, both groups
        for (int i = 0; i < 8; i++)
            drive(1'b0, 1'b1, 3'(i), 6'(i * 7), 7'h00, i < 4 ? "R4" : "R3");
        // R5 + R6: acknowledge, single pending cards
        drive(1'b0, 1'b1, 3'b101, 6'h3F, 7'h01, "R5");
        drive(1'b0, 1'b1, 3'b101, 6'h3F, 7'h40, "R6");
        drive(1'b0, 1'b1, 3'b101, 6'h3F, 7'h08, "R6");
        // R6: several and all pending
        drive(1'b0, 1'b1, 3'b101, 6'h3F, 7'h24, "R6");
        drive(1'b0, 1'b1, 3'b101, 6'h3F, 7'h7F, "R6");
        drive(1'b0, 1'b1, 3'b101, 6'h3F, 7'h00, "R6");
        // R7: pending but a different strobe or no cycle
        drive(1'b0, 1'b1, 3'b111, 6'h01, 7'h55, "R7");
        drive(1'b1, 1'b1, 3'b101, 6'h02, 7'h7F, "R7");
        drive(1'b0, 1'b0, 3'b101, 6'h04, 7'h2A, "R7");
        // R8: address forwarding patterns
        drive(1'b1, 1'b0, 3'd0, 6'h3F, 7'h00, "R8");
        drive(1'b1, 1'b0, 3'd0, 6'h00, 7'h00, "R8");
        drive(1'b0, 1'b1, 3'd2, 6'h21, 7'h00, "R8");
        drive(1'b1, 1'b0, 3'd0, 6'h12, 7'h00, "R8");
        repeat (3) @(negedge clk);
        drv_done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule